// File: doc/BRIEF.md
# External Data Memory Bus Cycle Generator with Programmable Strobe Width

This block turns a single start request into one complete read or write cycle on an external data memory bus. The address, data and strobes are on separate wires, with a distinct input and output data bus. The 24-bit address comes from one of two sources. The first is a three-byte pointer, where a page byte forms the top eight bits above a high byte and a low byte. The second is an 8-bit index register placed below a 16-bit upper-address register.

A 3-bit stretch setting chooses how long the read or write strobe stays asserted, from one to eight clocks, so that slow and fast devices can share the bus. The request, direction, address source, stretch setting and write data are all captured when the request is accepted. The caller may change them during the cycle without effect. A busy flag covers the whole cycle and a one-clock done pulse marks its end. For reads, the returned byte is held on a result port.

Top module: `xmem_stretch_if`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_rd`, `mem_wr`, `mem_dout_en`, `acc_busy` and `acc_done` are low.
- R2: With `acc_src_idx` = 0, `mem_addr` equals {`ptr_page`, `ptr_hi`, `ptr_lo`}, with the page byte on bits 23:16 and the low byte on bits 7:0.
- R3: With `acc_src_idx` = 1, `mem_addr` equals {`idx_upper`, `idx_reg`}, with the index on bits 7:0 and the upper register on bits 23:8.
- R4: A strobe lasts `stretch_sel` + 1 clocks: code 0 gives 1 clock and code 7 gives 8 clocks.
- R5: `mem_addr` and, for writes, `mem_dout` (= `acc_wdata`) stay constant for every clock of the strobe.
- R6: `acc_wr` = 0 raises only `mem_rd`, `acc_wr` = 1 raises only `mem_wr`, and the two are never high together.
- R7: `mem_dout_en` is high exactly in the clocks where `mem_wr` is high.
- R8: `acc_rdata` takes the `mem_din` value present in the last clock of the read strobe and holds it afterwards.
- R9: A request accepted at a clock edge makes `acc_busy` and the strobe high from that edge. Both fall together, and `acc_done` is high for exactly the one following clock.
- R10: A request arriving while `acc_busy` is high is ignored: no further strobe follows the current cycle.
- R11: Changing any address, stretch or write-data input after the accepting edge has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_req | input | 1 | Start request, accepted when idle |
| acc_wr | input | 1 | Direction: 1 write, 0 read |
| acc_src_idx | input | 1 | Address source: 0 pointer, 1 index register |
| ptr_page | input | 8 | Pointer page byte (address 23:16) |
| ptr_hi | input | 8 | Pointer high byte (address 15:8) |
| ptr_lo | input | 8 | Pointer low byte (address 7:0) |
| idx_upper | input | 16 | Upper address for index accesses (23:8) |
| idx_reg | input | 8 | Index register value (address 7:0) |
| stretch_sel | input | 3 | Strobe width code, width = code + 1 clocks |
| acc_wdata | input | 8 | Write data |
| mem_din | input | 8 | Data from external memory |
| mem_addr | output | 24 | External address bus |
| mem_dout | output | 8 | Data to external memory |
| mem_dout_en | output | 1 | Output-buffer enable for the data bus |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| acc_busy | output | 1 | Cycle in progress |
| acc_done | output | 1 | One-clock end-of-cycle pulse |
| acc_rdata | output | 8 | Captured read data |

## Verification
A vector table covers reads and writes from both address sources. It includes the smallest and largest stretch codes and all-ones and all-zero pointers, so that byte-order mistakes and source mix-ups produce distinct wrong addresses. During each read the memory model changes `mem_din` every clock. This separates sampling in the last strobe clock from sampling in an earlier one. After each accepted request the bench scrambles all inputs, which exposes any path that reads them live instead of from the captured copy. Directed cases cover reset and a second request issued while busy.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic {
      SRC_PTR = 1'b0,
      SRC_IDX = 1'b1
   } addr_src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/xmem_addr_gen.sv
module xmem_addr_gen #(
   parameter int ADDR_W = 24,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 8,
   localparam int HI_W  = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              src_idx,
   input  logic [BYTE_W-1:0] ptr_page,
   input  logic [BYTE_W-1:0] ptr_hi,
   input  logic [BYTE_W-1:0] ptr_lo,
   input  logic [HI_W-1:0]   idx_upper,
   input  logic [IDX_W-1:0]  idx_reg,
   input  logic              strobe,
   output logic [ADDR_W-1:0] addr_q
);
   import xmem_pkg::*;

   logic [ADDR_W-1:0] addr_nxt;
   addr_src_e         src;

   assign src = addr_src_e'(src_idx);

   always_comb begin
      unique case (src)
         SRC_IDX: addr_nxt = {idx_upper, idx_reg};
         default: addr_nxt = {ptr_page, ptr_hi, ptr_lo};
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       addr_q <= '0;
      else if (load) addr_q <= addr_nxt;
   end

   // R5: address frozen while a strobe continues
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
      (strobe && $past(strobe)) |-> $stable(addr_q));
endmodule

// File: rtl/xmem_strobe_seq.sv
module xmem_strobe_seq #(
   parameter int STR_W       = 3,
   parameter bit FIXED_WIDTH = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             dir_wr,
   input  logic [STR_W-1:0] stretch,
   output logic             load,
   output logic             last,
   output logic             rd,
   output logic             wr,
   output logic             oe,
   output logic             busy,
   output logic             done
);
   import xmem_pkg::*;

   localparam int LEN_W = STR_W + 1;

   seq_state_e state;
   logic       active;

   assign active = (state != ST_IDLE);
   assign load   = req && !active;

   generate
      if (FIXED_WIDTH) begin : g_fixed
         assign last = active;
      end else begin : g_stretch
         logic [STR_W-1:0] remain;
         always_ff @(posedge clk) begin
            if (rst)                remain <= '0;
            else if (load)          remain <= stretch;
            else if (active && remain != '0) remain <= remain - 1'b1;
         end
         assign last = active && (remain == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         rd    <= 1'b0;
         wr    <= 1'b0;
         oe    <= 1'b0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            state <= dir_wr ? ST_WRITE : ST_READ;
            rd    <= !dir_wr;
            wr    <= dir_wr;
            oe    <= dir_wr;
            busy  <= 1'b1;
         end else if (last) begin
            state <= ST_IDLE;
            rd    <= 1'b0;
            wr    <= 1'b0;
            oe    <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
         end
      end
   end

   // checker: strobe length against the captured code
   logic [LEN_W-1:0] chk_len;
   logic [LEN_W-1:0] chk_want;
   always_ff @(posedge clk) begin
      if (rst) begin
         chk_len  <= '0;
         chk_want <= '0;
      end else begin
         if (load) begin
            chk_len  <= '0;
            chk_want <= FIXED_WIDTH ? LEN_W'(1) : LEN_W'(stretch) + 1'b1;
         end else if (rd || wr) begin
            chk_len <= chk_len + 1'b1;
         end
      end
   end

   // R4: strobe width equals code plus one
   a_r4_width: assert property (@(posedge clk) disable iff (rst)
      $fell(rd || wr) |-> (chk_len == chk_want));
   // R6: strobes mutually exclusive
   a_r6_excl: assert property (@(posedge clk) disable iff (rst)
      !(rd && wr));
   // R7: buffer enable tracks the write strobe
   a_r7_oe: assert property (@(posedge clk) disable iff (rst)
      oe == wr);
   // R9: done lasts one clock, strobes imply busy
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r9_busy_cover: assert property (@(posedge clk) disable iff (rst)
      (rd || wr) |-> busy);
   a_r9_done_after: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);
endmodule

// File: rtl/xmem_data_path.sv
module xmem_data_path #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              cap,
   input  logic              wr_strobe,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] mem_din,
   output logic [BYTE_W-1:0] dout_q,
   output logic [BYTE_W-1:0] rdata_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (load) dout_q  <= wdata;
         if (cap)  rdata_q <= mem_din;
      end
   end

   // R5: write data frozen across the write strobe
   a_r5_wdata_stable: assert property (@(posedge clk) disable iff (rst)
      (wr_strobe && $past(wr_strobe)) |-> $stable(dout_q));
   // R8: read data holds when no capture
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(cap) |-> $stable(rdata_q));
endmodule

// File: rtl/xmem_stretch_if.sv
module xmem_stretch_if #(
   parameter int ADDR_W      = 24,
   parameter int BYTE_W      = 8,
   parameter int IDX_W       = 8,
   parameter int STR_W       = 3,
   parameter bit FIXED_WIDTH = 1'b0,
   localparam int HI_W       = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_req,
   input  logic              acc_wr,
   input  logic              acc_src_idx,
   input  logic [BYTE_W-1:0] ptr_page,
   input  logic [BYTE_W-1:0] ptr_hi,
   input  logic [BYTE_W-1:0] ptr_lo,
   input  logic [HI_W-1:0]   idx_upper,
   input  logic [IDX_W-1:0]  idx_reg,
   input  logic [STR_W-1:0]  stretch_sel,
   input  logic [BYTE_W-1:0] acc_wdata,
   input  logic [BYTE_W-1:0] mem_din,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_dout,
   output logic              mem_dout_en,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              acc_busy,
   output logic              acc_done,
   output logic [BYTE_W-1:0] acc_rdata
);
   if (ADDR_W != 3 * BYTE_W) begin : g_bad_addr_w
      $error("ADDR_W must hold exactly three pointer bytes");
   end
   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx_w
      $error("IDX_W must be between 1 and ADDR_W-1");
   end
   if (STR_W < 1) begin : g_bad_str_w
      $error("STR_W must be at least 1");
   end

   logic load;
   logic last;

   xmem_strobe_seq #(
      .STR_W       (STR_W),
      .FIXED_WIDTH (FIXED_WIDTH)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .req     (acc_req),
      .dir_wr  (acc_wr),
      .stretch (stretch_sel),
      .load    (load),
      .last    (last),
      .rd      (mem_rd),
      .wr      (mem_wr),
      .oe      (mem_dout_en),
      .busy    (acc_busy),
      .done    (acc_done)
   );

   xmem_addr_gen #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W),
      .IDX_W  (IDX_W)
   ) u_addr (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .src_idx   (acc_src_idx),
      .ptr_page  (ptr_page),
      .ptr_hi    (ptr_hi),
      .ptr_lo    (ptr_lo),
      .idx_upper (idx_upper),
      .idx_reg   (idx_reg),
      .strobe    (mem_rd || mem_wr),
      .addr_q    (mem_addr)
   );

   xmem_data_path #(
      .BYTE_W (BYTE_W)
   ) u_data (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .cap       (mem_rd && last),
      .wr_strobe (mem_wr),
      .wdata     (acc_wdata),
      .mem_din   (mem_din),
      .dout_q    (mem_dout),
      .rdata_q   (acc_rdata)
   );

   // R10: no new cycle starts while busy
   a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
      (acc_busy && !acc_done && $past(acc_busy)) |-> $stable(mem_addr) || !acc_busy);
endmodule

// File: tb/tb_xmem_stretch_if.sv
module tb_xmem_stretch_if;
   logic        clk = 1'b0;
   logic        rst;
   logic        acc_req, acc_wr, acc_src_idx;
   logic [7:0]  ptr_page, ptr_hi, ptr_lo, idx_reg, acc_wdata, mem_din;
   logic [15:0] idx_upper;
   logic [2:0]  stretch_sel;
   logic [23:0] mem_addr;
   logic [7:0]  mem_dout, acc_rdata;
   logic        mem_dout_en, mem_rd, mem_wr, acc_busy, acc_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   xmem_stretch_if dut (
      .clk(clk), .rst(rst), .acc_req(acc_req), .acc_wr(acc_wr),
      .acc_src_idx(acc_src_idx), .ptr_page(ptr_page), .ptr_hi(ptr_hi),
      .ptr_lo(ptr_lo), .idx_upper(idx_upper), .idx_reg(idx_reg),
      .stretch_sel(stretch_sel), .acc_wdata(acc_wdata), .mem_din(mem_din),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .acc_busy(acc_busy),
      .acc_done(acc_done), .acc_rdata(acc_rdata)
   );

   typedef struct packed {
      logic        wr;
      logic        src;
      logic [7:0]  page;
      logic [7:0]  hi;
      logic [7:0]  lo;
      logic [15:0] iup;
      logic [7:0]  ival;
      logic [2:0]  str;
      logic [7:0]  wdat;
      logic [7:0]  rbase;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 8'h12, 8'h34, 8'h56, 16'h0000, 8'h00, 3'd0, 8'h00, 8'h10},
      '{1'b1, 1'b0, 8'hAB, 8'hCD, 8'hEF, 16'h0000, 8'h00, 3'd7, 8'h3C, 8'h00},
      '{1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 16'hBEEF, 8'h42, 3'd3, 8'h00, 8'h80},
      '{1'b1, 1'b1, 8'h77, 8'h66, 8'h55, 16'h0001, 8'hFF, 3'd1, 8'hA5, 8'h00},
      '{1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 16'h1234, 8'h99, 3'd7, 8'h00, 8'hC0},
      '{1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 16'hFFFF, 8'hEE, 3'd0, 8'h81, 8'h00}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_access(input vec_t v, input bit scramble);
      logic [23:0] exp_addr;
      int          k;
      bit          addr_ok, excl_ok, oe_ok, dout_ok, busy_ok;
      exp_addr = v.src ? {v.iup, v.ival} : {v.page, v.hi, v.lo};
      acc_req = 1'b1; acc_wr = v.wr; acc_src_idx = v.src;
      ptr_page = v.page; ptr_hi = v.hi; ptr_lo = v.lo;
      idx_upper = v.iup; idx_reg = v.ival; stretch_sel = v.str;
      acc_wdata = v.wdat; mem_din = 8'h00;
      @(negedge clk);
      acc_req = 1'b0;
      if (scramble) begin   // R11: disturb all inputs after acceptance
         ptr_page = ~v.page; ptr_hi = ~v.hi; ptr_lo = ~v.lo;
         idx_upper = ~v.iup; idx_reg = ~v.ival; acc_src_idx = ~v.src;
         stretch_sel = ~v.str; acc_wdata = ~v.wdat; acc_wr = ~v.wr;
      end
      k = 0;
      addr_ok = 1; excl_ok = 1; oe_ok = 1; dout_ok = 1; busy_ok = 1;
      while ((mem_rd || mem_wr) && k < 20) begin
         if (mem_addr != exp_addr) addr_ok = 0;
         if (v.wr ? (!mem_wr || mem_rd) : (!mem_rd || mem_wr)) excl_ok = 0;
         if (mem_dout_en != mem_wr) oe_ok = 0;
         if (v.wr && mem_dout != v.wdat) dout_ok = 0;
         if (!acc_busy || acc_done) busy_ok = 0;
         mem_din = v.rbase + 8'(k);
         k++;
         @(negedge clk);
      end
      check(addr_ok, v.src ? "R3" : "R2", "address during strobe", mem_addr, exp_addr);
      check(addr_ok, "R5", "address stable", mem_addr, exp_addr);
      check(excl_ok, "R6", "strobe direction", {mem_rd, mem_wr}, {~v.wr, v.wr});
      check(oe_ok, "R7", "buffer enable", mem_dout_en, mem_wr);
      if (v.wr) check(dout_ok, "R5", "write data", mem_dout, v.wdat);
      check(busy_ok, "R9", "busy during strobe", acc_busy, 1);
      check(k == int'(v.str) + 1, scramble ? "R11" : "R4", "strobe width", k, int'(v.str) + 1);
      check(acc_done && !acc_busy, "R9", "done after strobe", {acc_done, acc_busy}, 2'b10);
      if (!v.wr)
         check(acc_rdata == v.rbase + 8'(v.str), "R8", "read data", acc_rdata, v.rbase + 8'(v.str));
      @(negedge clk);
      check(!acc_done, "R9", "done one clock", acc_done, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; acc_req = 1'b0; acc_wr = 1'b0; acc_src_idx = 1'b0;
      ptr_page = '0; ptr_hi = '0; ptr_lo = '0; idx_upper = '0; idx_reg = '0;
      stretch_sel = '0; acc_wdata = '0; mem_din = '0;
      acc_req = 1'b1;   // R1: request during reset has no effect
      repeat (3) @(negedge clk);
      check({mem_rd, mem_wr, mem_dout_en, acc_busy, acc_done} == 5'b0, "R1",
            "outputs in reset", {mem_rd, mem_wr, mem_dout_en, acc_busy, acc_done}, 0);
      acc_req = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check({mem_rd, mem_wr, mem_dout_en, acc_busy, acc_done} == 5'b0, "R1",
            "outputs after reset", {mem_rd, mem_wr, mem_dout_en, acc_busy, acc_done}, 0);

      for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b0);
      for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b1);

      // R10: second request while busy is dropped
      acc_req = 1'b1; acc_wr = 1'b0; acc_src_idx = 1'b0;
      ptr_page = 8'h01; ptr_hi = 8'h02; ptr_lo = 8'h03; stretch_sel = 3'd4;
      @(negedge clk);
      acc_req = 1'b0;
      @(negedge clk);
      acc_req = 1'b1; acc_wr = 1'b1; ptr_lo = 8'h99;
      @(negedge clk);
      acc_req = 1'b0;
      while (acc_busy) @(negedge clk);
      begin
         bit quiet = 1;
         for (int j = 0; j < 5; j++) begin
            if (mem_rd || mem_wr || acc_busy) quiet = 0;
            @(negedge clk);
         end
         check(quiet, "R10", "no strobe after ignored request", {mem_rd, mem_wr, acc_busy}, 0);
      end
      check(mem_addr == 24'h010203, "R10", "address of first request kept", mem_addr, 24'h010203);

      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule